// File: doc/BRIEF.md
# Oversampled Serial Frame Receiver with Ninth-Bit Filter

This block receives asynchronous serial frames of eleven bit times: a low start bit, eight data bits sent least significant first, a ninth bit, and a stop bit. The serial line first goes through a synchronizer. The block then samples it on a clock enable that pulses at sixteen times the bit rate. Each bit is decided by a two-of-three vote of samples taken from the middle of the bit time. A start bit that votes high is treated as noise, and the receiver goes back to watching the line.

A finished frame reaches the outputs only if the previous frame has been taken, which means the completion flag is clear. When the address filter is enabled, the frame's ninth bit must also be 1. This lets a node on a shared line ignore data frames until an address frame, marked by a ninth bit of 1, arrives. The host clears the completion flag with a dedicated clear input.

Top module: `mprx_rx`

## Requirements
- R1: After reset, `rx_data` is 0, `rx_bit9` is 0 and `rx_done` is 0.
- R2: A frame is delivered as follows. The first data bit on the line goes to `rx_data[0]` and the eighth data bit goes to `rx_data[7]`. The ninth bit goes to `rx_bit9`, and `rx_done` becomes 1.
- R3: Each bit value is the majority of three samples taken at oversampling counter states 7, 8 and 9 of that bit. State 0 is the sample tick on which the falling edge is accepted. A single disagreeing sample does not change the bit, two disagreeing samples do, and samples outside states 7 to 9 have no effect.
- R4: If the start bit votes 1, the frame is abandoned with the outputs unchanged, and the next falling edge starts a new frame.
- R5: While `rx_done` is 1, a newly completed frame is dropped. `rx_data`, `rx_bit9` and `rx_done` keep their values.
- R6: With `filt_en` at 1, a frame whose ninth bit is 0 is dropped with the outputs unchanged, and a frame whose ninth bit is 1 is delivered. With `filt_en` at 0, both kinds of frame are delivered.
- R7: The stop bit's value does not affect `rx_data`, `rx_bit9` or `rx_done`. A frame that follows one with a low stop bit is still received.
- R8: `flag_clr` clears `rx_done`. When `flag_clr` arrives in the same cycle as the delivery decision, the decision uses the flag value from before that cycle, and setting the flag wins over clearing it.
- R9: The receiver advances only on cycles where `tick16` is 1. With `tick16` held at 0 no frame is received, and with `tick16` pulsing once every third cycle frames are received correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | Sample enable at 16 times the bit rate |
| rxd_in | input | 1 | Asynchronous serial input, idle high |
| filt_en | input | 1 | Accept only frames whose ninth bit is 1 |
| flag_clr | input | 1 | Clears the completion flag |
| rx_data | output | 8 | Last delivered data byte |
| rx_bit9 | output | 1 | Last delivered ninth bit |
| rx_done | output | 1 | Completion flag: a delivered frame is waiting |

## Verification
The host's flag clear can land on the same cycle as the final-shift delivery decision. This is the one place where two functions compete for the completion flag. The bench places a `flag_clr` pulse exactly on the decision cycle, which it counts from the first start-bit slot with the sample enable held high. It does this twice: once with the flag already set, where the frame must be dropped and the flag must end clear, and once with the flag clear, where the frame must be delivered and the flag must end set. Glitch masks placed on individual sample slots, together with the ninth-bit filter, are judged against outputs that the bench computes from the frame it sent.

// File: rtl/mprx_pkg.sv
package mprx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DATA = 2'd1,
    ST_STOP = 2'd2
  } rx_state_e;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/mprx_sync.sv
module mprx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic q_out
);

  logic [STAGES-1:0] stg_q;
  logic [STAGES-1:0] stg_d;

  always_comb begin
    stg_d = {stg_q[STAGES-2:0], d_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '1;
    else        stg_q <= stg_d;
  end

  assign q_out = stg_q[STAGES-1];

endmodule

// File: rtl/mprx_voter.sv
module mprx_voter #(
  parameter int OVS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic restart,
  input  logic sin,
  output logic strobe,
  output logic vote
);
  import mprx_pkg::*;

  localparam int CW  = $clog2(OVS);
  localparam int MID = OVS / 2;
  localparam logic [CW-1:0] ST_A = CW'(MID - 1);
  localparam logic [CW-1:0] ST_B = CW'(MID);
  localparam logic [CW-1:0] ST_C = CW'(MID + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          sa_q, sa_d, sb_q, sb_d;

  always_comb begin
    cnt_d = cnt_q;
    sa_d  = sa_q;
    sb_d  = sb_q;
    if (restart)   cnt_d = '0;
    else if (tick) cnt_d = cnt_q + 1'b1;
    if (tick && cnt_q == ST_A) sa_d = sin;
    if (tick && cnt_q == ST_B) sb_d = sin;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sa_q  <= 1'b1;
      sb_q  <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      sa_q  <= sa_d;
      sb_q  <= sb_d;
    end
  end

  assign strobe = tick && (cnt_q == ST_C);
  assign vote   = maj3(sa_q, sb_q, sin);

endmodule

// File: rtl/mprx_ctrl.sv
module mprx_ctrl #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          sin,
  input  logic          strobe,
  input  logic          vote,
  input  logic          filt_en,
  input  logic          flag_clr,
  output logic          restart,
  output logic [DW-1:0] rx_data,
  output logic          rx_bit9,
  output logic          rx_done
);
  import mprx_pkg::*;

  localparam int SW = DW + 1;

  rx_state_e     state_q, state_d;
  logic          prev_q, prev_d;
  logic [SW-1:0] shreg_q, shreg_d;
  logic [DW-1:0] data_q, data_d, byte_in;
  logic          bit9_q, bit9_d, done_q, done_d;
  logic          last_shift, deliver;

  // Before the final shift the start bit sits at the top and the first
  // data bit right below it, so the byte is read bit-reversed.
  for (genvar i = 0; i < DW; i++) begin : g_rev
    assign byte_in[i] = shreg_q[DW-1-i];
  end

  always_comb begin
    state_d    = state_q;
    shreg_d    = shreg_q;
    prev_d     = tick ? sin : prev_q;
    restart    = 1'b0;
    last_shift = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (tick && prev_q && !sin) begin
          restart = 1'b1;
          shreg_d = '1;
          state_d = ST_DATA;
        end
      end
      ST_DATA: begin
        if (strobe) begin
          if ((&shreg_q) && vote) begin
            state_d = ST_IDLE;
          end else begin
            shreg_d = {shreg_q[SW-2:0], vote};
            if (!shreg_q[SW-1]) begin
              last_shift = 1'b1;
              state_d    = ST_STOP;
            end
          end
        end
      end
      ST_STOP: begin
        if (strobe) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    deliver = last_shift && !done_q && (!filt_en || vote);
    data_d  = deliver ? byte_in : data_q;
    bit9_d  = deliver ? vote : bit9_q;
    if (deliver)       done_d = 1'b1;
    else if (flag_clr) done_d = 1'b0;
    else               done_d = done_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      prev_q  <= 1'b1;
      shreg_q <= '1;
      data_q  <= '0;
      bit9_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      prev_q  <= prev_d;
      shreg_q <= shreg_d;
      data_q  <= data_d;
      bit9_q  <= bit9_d;
      done_q  <= done_d;
    end
  end

  assign rx_data = data_q;
  assign rx_bit9 = bit9_q;
  assign rx_done = done_q;

endmodule

// File: rtl/mprx_rx.sv
module mprx_rx #(
  parameter int DW          = 8,
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick16,
  input  logic          rxd_in,
  input  logic          filt_en,
  input  logic          flag_clr,
  output logic [DW-1:0] rx_data,
  output logic          rx_bit9,
  output logic          rx_done
);

  logic [1:0] rst_pipe_q;
  logic       rst_int_n;
  logic       sin, restart, strobe, vote;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  mprx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d_in  (rxd_in),
    .q_out (sin)
  );

  mprx_voter #(.OVS(OVS)) u_voter (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .tick    (tick16),
    .restart (restart),
    .sin     (sin),
    .strobe  (strobe),
    .vote    (vote)
  );

  mprx_ctrl #(.DW(DW)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .tick     (tick16),
    .sin      (sin),
    .strobe   (strobe),
    .vote     (vote),
    .filt_en  (filt_en),
    .flag_clr (flag_clr),
    .restart  (restart),
    .rx_data  (rx_data),
    .rx_bit9  (rx_bit9),
    .rx_done  (rx_done)
  );

endmodule

// File: rtl/mprx_rx_chk.sv
module mprx_rx_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick16,
  input logic          filt_en,
  input logic          flag_clr,
  input logic [DW-1:0] rx_data,
  input logic          rx_bit9,
  input logic          rx_done
);

  // R5
  pending_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && !flag_clr) |=> rx_done);

  // R5
  pending_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> ($stable(rx_data) && $stable(rx_bit9)));

  // R8
  clear_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_done) |-> $past(flag_clr));

  // R6
  filter_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rx_done) && $past(filt_en)) |-> rx_bit9);

  // R9
  tick_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_done) |-> $past(tick16));

endmodule

bind mprx_rx mprx_rx_chk #(.DW(DW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick16   (tick16),
  .filt_en  (filt_en),
  .flag_clr (flag_clr),
  .rx_data  (rx_data),
  .rx_bit9  (rx_bit9),
  .rx_done  (rx_done)
);

// File: tb/mprx_rx_tb.sv
module mprx_rx_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick16 = 1'b0;
  logic       rxd_in = 1'b1;
  logic       filt_en = 1'b0;
  logic       flag_clr = 1'b0;
  logic [7:0] rx_data;
  logic       rx_bit9;
  logic       rx_done;

  int total = 0;
  int fails = 0;
  int tick_div = 1;
  int tcnt = 0;
  logic [9:0] expv;

  always #4 clk = ~clk;

  mprx_rx u_dut (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd_in(rxd_in),
    .filt_en(filt_en), .flag_clr(flag_clr),
    .rx_data(rx_data), .rx_bit9(rx_bit9), .rx_done(rx_done)
  );

  always @(negedge clk) begin
    tcnt = tcnt + 1;
    tick16 = (tick_div != 0) && ((tcnt % ((tick_div < 1) ? 1 : tick_div)) == 0);
  end

  task automatic chk(input string tag, input logic [9:0] exp_v);
    logic [9:0] act;
    act = {rx_done, rx_bit9, rx_data};
    total++;
    if (act !== exp_v) begin
      fails++;
      $display("FAIL %s: got done/bit9/data=%b/%b/%02h expected %b/%b/%02h",
               tag, act[9], act[8], act[7:0], exp_v[9], exp_v[8], exp_v[7:0]);
    end
  endtask

  task automatic clr();
    @(negedge clk) flag_clr = 1'b1;
    @(negedge clk) flag_clr = 1'b0;
    expv[9] = 1'b0;
  endtask

  // One slot per clock; a bit lasts 16 sample ticks.
  task automatic send(input logic [7:0] d, input logic b9, input logic stp,
                      input int gbit, input logic [15:0] gmask, input int clr_slot);
    int bw, per, total_slots, bi, off;
    logic v;
    bw = (tick_div < 1) ? 1 : tick_div;
    per = 16 * bw;
    total_slots = 11 * per + 4 * bw;
    for (int s = 0; s < total_slots; s++) begin
      bi  = s / per;
      off = (s % per) / bw;
      if (bi == 0)       v = 1'b0;
      else if (bi <= 8)  v = d[bi-1];
      else if (bi == 9)  v = b9;
      else if (bi == 10) v = stp;
      else               v = 1'b1;
      if (bi == gbit && gmask[off]) v = ~v;
      @(negedge clk);
      rxd_in = v;
      flag_clr = (s == clr_slot);
    end
    @(negedge clk);
    flag_clr = 1'b0;
    rxd_in = 1'b1;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    // R1 reset state
    chk("R1 reset", 10'b0);

    // R2 sweep over every byte, ninth bit = parity
    for (int i = 0; i < 256; i++) begin
      clr();
      send(8'(i), ^(8'(i)), 1'b1, -1, 16'h0, -1);
      expv = {1'b1, ^(8'(i)), 8'(i)};
      chk("R2 frame", expv);
    end

    // R5 pending flag: frame dropped, outputs held
    send(8'hC3, 1'b1, 1'b1, -1, 16'h0, -1);
    chk("R5 pending drop", expv);

    // R8 clear on decision cycle with flag set: dropped, flag ends 0
    send(8'h3C, 1'b1, 1'b1, -1, 16'h0, 156);
    expv[9] = 1'b0;
    chk("R8 clear vs drop", expv);
    // R8 clear on decision cycle with flag clear: set wins
    send(8'h66, 1'b1, 1'b1, -1, 16'h0, 156);
    expv = {1'b1, 1'b1, 8'h66};
    chk("R8 set wins", expv);
    clr();
    chk("R8 clear", expv);

    // R3 majority voting (sample slots sit at bit offsets 8,9,10)
    clr(); send(8'h5A, 1'b0, 1'b1, 1, 16'h0200, -1);
    expv = {1'b1, 1'b0, 8'h5A}; chk("R3 one sample", expv);
    clr(); send(8'h5A, 1'b0, 1'b1, 1, 16'h0300, -1);
    expv = {1'b1, 1'b0, 8'h5B}; chk("R3 two samples", expv);
    clr(); send(8'h5A, 1'b0, 1'b1, 1, 16'h0600, -1);
    expv = {1'b1, 1'b0, 8'h5B}; chk("R3 two late samples", expv);
    clr(); send(8'hA5, 1'b0, 1'b1, 8, 16'h0500, -1);
    expv = {1'b1, 1'b0, 8'h25}; chk("R3 outer samples", expv);
    clr(); send(8'hA5, 1'b1, 1'b1, 2, 16'hF87F, -1);
    expv = {1'b1, 1'b1, 8'hA5}; chk("R3 outside window", expv);

    // R4 false start then a real frame
    clr();
    @(negedge clk) rxd_in = 1'b0;
    repeat (2) @(negedge clk);
    rxd_in = 1'b1;
    repeat (40) @(negedge clk);
    chk("R4 false start", expv);
    send(8'h81, 1'b1, 1'b1, -1, 16'h0, -1);
    expv = {1'b1, 1'b1, 8'h81}; chk("R4 recovery", expv);

    // R7 low stop bit, then a normal frame
    clr(); send(8'h42, 1'b1, 1'b0, -1, 16'h0, -1);
    expv = {1'b1, 1'b1, 8'h42}; chk("R7 low stop", expv);
    clr(); send(8'h24, 1'b0, 1'b1, -1, 16'h0, -1);
    expv = {1'b1, 1'b0, 8'h24}; chk("R7 after low stop", expv);

    // R6 filter enabled
    filt_en = 1'b1;
    for (int i = 0; i < 32; i++) begin
      clr();
      send(8'(i * 8 + 3), 1'b0, 1'b1, -1, 16'h0, -1);
      chk("R6 filtered drop", expv);
      send(8'(i * 8 + 3), 1'b1, 1'b1, -1, 16'h0, -1);
      expv = {1'b1, 1'b1, 8'(i * 8 + 3)};
      chk("R6 address pass", expv);
    end
    filt_en = 1'b0;

    // R9 no tick: nothing received
    clr();
    tick_div = 0;
    send(8'h99, 1'b1, 1'b1, -1, 16'h0, -1);
    chk("R9 no tick", expv);
    // R9 slow tick
    tick_div = 3;
    repeat (10) @(negedge clk);
    send(8'h99, 1'b1, 1'b1, -1, 16'h0, -1);
    expv = {1'b1, 1'b1, 8'h99}; chk("R9 slow tick", expv);
    clr();
    send(8'h17, 1'b0, 1'b1, -1, 16'h0, -1);
    expv = {1'b1, 1'b0, 8'h17}; chk("R9 slow tick 2", expv);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule